// File: doc/BRIEF.md
# Converter Serial Frame Engine

This block is the digital serial front end of a multi-channel sampling converter. It acts as a serial-peripheral slave with a clock pin, a data-in pin, a data-out pin and an active-low chip select. It runs on a local system clock and oversamples the serial pins through synchronizers. A falling chip select opens a frame and pulses a sample strobe toward the analog side. At the same instant the block captures the converted result and its channel number from a parallel input, formats them into a 16-bit word, and shifts that word out MSB-first. During the same frame it shifts a 16-bit control word in from the data-in pin.

The outgoing word takes one of two layouts, chosen by a mode pin. In the tagged layout the word is the channel number followed by the result. In the padded layout it is a zero, the result, and three zeros. A second pin selects a reduced-resolution variant that clears the two lowest result bits in either layout.

The received control word is presented on a parallel output with a single-cycle valid flag. This output stream has no ready input and cannot apply back-pressure. A consumer must take the word in the cycle the flag is high. The word then stays on the output until the next complete frame replaces it. The parallel result input is a plain level input that is sampled once per frame.

Top module: `adc_spi_frame_engine`

## Requirements
- R1: A synchronized falling edge of `spi_cs_n` produces a `sample_stb` pulse exactly one `clk` cycle wide and raises `spi_dout_oe`. A rising edge of `spi_cs_n` drops `spi_dout_oe`. While `spi_dout_oe` is low, `spi_dout` is 0.
- R2: `conv_result`, `conv_chan`, `tag_mode` and `low_res` are sampled at the chip-select falling edge. Changes to them later in the frame do not alter the word shifted out in that frame.
- R3: `spi_din` is captured on each rising `spi_sclk` edge of a frame, MSB first. After the 16th rising edge, `ctl_valid` is high for one `clk` cycle and `ctl_word` holds the 16 received bits, with the first bit received at bit 15.
- R4: The first output bit (word bit 15) is on `spi_dout` once the frame opens. Each falling `spi_sclk` edge that follows at least one rising edge in the same frame moves the output to the next lower bit.
- R5: With `tag_mode`=1, the output word is `{conv_chan[3:0], result[11:0]}`.
- R6: With `tag_mode`=0, the output word is `{1'b0, result[11:0], 3'b000}`.
- R7: With `low_res`=1, bits 1:0 of the result field are 0 in both layouts.
- R8: A frame with the clock idling low (polarity 0, phase 0) and a frame with the clock idling high (polarity 1, phase 1) produce the same output word and capture the same control word.
- R9: Rising edges beyond the 16th in a frame move `spi_dout` through zeros. They do not change `ctl_word` and do not raise `ctl_valid` again.
- R10: A chip-select rising edge after fewer than 16 rising clock edges ends the frame without `ctl_valid`. The next frame starts counting from zero.
- R11: `ctl_word` changes only in a cycle in which `ctl_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select; its falling edge opens a frame |
| spi_din | input | 1 | Serial data into the block |
| spi_dout | output | 1 | Serial data out of the block |
| spi_dout_oe | output | 1 | Output enable for the pad driver of `spi_dout` |
| conv_result | input | 12 | Converted sample |
| conv_chan | input | 4 | Channel number of the sample |
| tag_mode | input | 1 | 1: tagged layout, 0: padded layout |
| low_res | input | 1 | 1: clear the two lowest result bits |
| sample_stb | output | 1 | One-cycle strobe marking the sampling instant |
| ctl_word | output | 16 | Last complete control word received |
| ctl_valid | output | 1 | One-cycle flag for a new `ctl_word`; no back-pressure |

## Verification
Some properties are checked on every cycle: the strobe and valid pulses are one cycle wide, the output enable follows the chip-select edges, the data-out pin stays quiet while disabled, the bit counter never passes 16, and the control word moves only with its valid flag. Other behaviours need whole frames from a modelled master, so only the bench scenarios can show them. These are the bit-exact layouts for both modes and the reduced-resolution variant, equality across the two clock polarities, the isolation of the word from input changes in mid-frame, zero fill on surplus clocks, and the silent drop of a short frame.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic {
    LAYOUT_PAD = 1'b0,
    LAYOUT_TAG = 1'b1
  } layout_e;

  localparam int unsigned SPI_WORD_W = 16;
  localparam int unsigned SPI_RES_W  = 12;
  localparam int unsigned SPI_CHAN_W = 4;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{INIT}};
      last  <= INIT;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;
endmodule

// File: rtl/spi_word_fmt.sv
module spi_word_fmt
  import adc_spi_pkg::*;
#(
  parameter int unsigned WORD_W   = SPI_WORD_W,
  parameter int unsigned RES_W    = SPI_RES_W,
  parameter int unsigned CHAN_W   = SPI_CHAN_W,
  parameter int unsigned LOW_DROP = 2
) (
  input  logic [RES_W-1:0]  result,
  input  logic [CHAN_W-1:0] chan,
  input  layout_e           layout,
  input  logic              low_res,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned PAD_W = WORD_W - 1 - RES_W;

  logic [RES_W-1:0] res_eff;

  always_comb begin
    res_eff = result;
    if (low_res) res_eff[LOW_DROP-1:0] = '0;
  end

  always_comb begin
    if (layout == LAYOUT_TAG) word = {chan, res_eff};
    else                      word = {1'b0, res_eff, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              din_bit,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              started,
  output logic [$clog2(WORD_W+1)-1:0] bit_cnt
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_sh;

  assign next_sh = {shreg[WORD_W-2:0], din_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      word    <= '0;
      valid   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      valid <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (bit_stb) begin
        shreg <= next_sh;
        if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          word  <= next_sh;
          valid <= 1'b1;
        end
      end
    end
  end

  assign started = (bit_cnt != '0);
endmodule

// File: rtl/spi_tx_ser.sv
module spi_tx_ser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              out_bit
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= load_word;
    else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  assign out_bit = shreg[WORD_W-1];
endmodule

// File: rtl/adc_spi_frame_engine.sv
module adc_spi_frame_engine
  import adc_spi_pkg::*;
#(
  parameter int unsigned WORD_W      = SPI_WORD_W,
  parameter int unsigned RES_W       = SPI_RES_W,
  parameter int unsigned CHAN_W      = SPI_CHAN_W,
  parameter int unsigned LOW_DROP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              spi_dout_oe,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              tag_mode,
  input  logic              low_res,
  output logic              sample_stb,
  output logic [WORD_W-1:0] ctl_word,
  output logic              ctl_valid
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic cs_lvl, cs_rise, cs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic din_lvl, din_rise, din_fall;
  logic active;
  logic started;
  logic tx_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] fmt_word;
  layout_e           layout;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin(spi_cs_n),
    .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  spi_pin_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .pin(spi_sclk),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  spi_pin_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .pin(spi_din),
    .lvl(din_lvl), .rise(din_rise), .fall(din_fall)
  );

  // Frame window and sampling strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= cs_fall;
      if (cs_fall)      active <= 1'b1;
      else if (cs_rise) active <= 1'b0;
    end
  end

  assign layout = tag_mode ? LAYOUT_TAG : LAYOUT_PAD;

  spi_word_fmt #(
    .WORD_W(WORD_W), .RES_W(RES_W), .CHAN_W(CHAN_W), .LOW_DROP(LOW_DROP)
  ) u_fmt (
    .result(conv_result), .chan(conv_chan), .layout(layout),
    .low_res(low_res), .word(fmt_word)
  );

  spi_rx_deser #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_stb(sclk_rise),
    .din_bit(din_lvl), .word(ctl_word), .valid(ctl_valid),
    .started(started), .bit_cnt(bit_cnt)
  );

  // The output advances only on a falling edge that follows a rising edge.
  // With the clock idling high, the leading falling edge therefore leaves the
  // first bit in place.
  spi_tx_ser #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cs_fall), .load_word(fmt_word),
    .shift(active & sclk_fall & started), .out_bit(tx_bit)
  );

  assign spi_dout    = active & tx_bit;
  assign spi_dout_oe = active;
endmodule

// File: rtl/adc_spi_frame_chk.sv
module adc_spi_frame_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              frame_act,
  input logic              sample_stb,
  input logic              spi_dout,
  input logic              spi_dout_oe,
  input logic              ctl_valid,
  input logic [WORD_W-1:0] ctl_word,
  input logic [CNT_W-1:0]  bit_cnt
);
  assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sample_stb && spi_dout_oe));

  assert_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !spi_dout_oe);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_dout_oe |-> !spi_dout);

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  assert_valid_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> $past(frame_act));

  assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |-> $stable(ctl_word));
endmodule

bind adc_spi_frame_engine adc_spi_frame_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .frame_act(active), .sample_stb(sample_stb), .spi_dout(spi_dout),
  .spi_dout_oe(spi_dout_oe), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
  .bit_cnt(bit_cnt)
);

// File: tb/adc_spi_frame_engine_tb_top.sv
`timescale 1ns/1ps
module adc_spi_frame_engine_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_din = 1'b0;
  logic        spi_dout, spi_dout_oe;
  logic [11:0] conv_result = '0;
  logic [3:0]  conv_chan = '0;
  logic        tag_mode = 1'b0;
  logic        low_res = 1'b0;
  logic        sample_stb;
  logic [15:0] ctl_word;
  logic        ctl_valid;

  int total = 0;
  int bad = 0;
  int stb_seen = 0;
  int valid_seen = 0;
  int frames = 0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  adc_spi_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_din(spi_din), .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
    .conv_result(conv_result), .conv_chan(conv_chan), .tag_mode(tag_mode),
    .low_res(low_res), .sample_stb(sample_stb), .ctl_word(ctl_word),
    .ctl_valid(ctl_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word(input logic [11:0] r, input logic [3:0] c,
                                             input bit tag, input bit lr);
    logic [11:0] re;
    re = lr ? {r[11:2], 2'b00} : r;
    return tag ? {c, re} : {1'b0, re, 3'b000};
  endfunction

  // Monitor: pops the expected control word whenever the design flags one.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_stb) stb_seen++;
      if (ctl_valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected ctl_valid", {16'h0, ctl_word}, 32'h0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(ctl_word == e, "R3 ctl_word", {16'h0, ctl_word}, {16'h0, e});
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one frame as a master with clock idle level cpol.
  task automatic frame(input bit cpol, input int nbits, input logic [15:0] dw,
                       input logic [11:0] r, input logic [3:0] c, input bit tag,
                       input bit lr, input string req);
    logic [15:0] got;
    logic [15:0] exp;
    bit extra_ok;
    got = '0;
    extra_ok = 1'b1;
    exp = model_word(r, c, tag, lr);
    conv_result = r; conv_chan = c; tag_mode = tag; low_res = lr;
    spi_sclk = cpol;
    wait_clk(2 * HALF);
    if (nbits >= 16) exp_q.push_back(dw);
    frames++;
    spi_cs_n = 1'b0;
    wait_clk(2 * HALF);
    // R2: inputs disturbed after the frame opened must not matter.
    conv_result = ~r; conv_chan = ~c; tag_mode = ~tag; low_res = ~lr;
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_din = (i < 16) ? dw[15 - i] : ~dw[i % 16];
      wait_clk(HALF);
      if (i < 16) got[15 - i] = spi_dout;
      else if (spi_dout !== 1'b0) extra_ok = 1'b0;
      spi_sclk = 1'b1;
      wait_clk(HALF);
    end
    spi_sclk = cpol;
    wait_clk(HALF);
    if (nbits >= 16) begin
      check(got == exp, req, {16'h0, got}, {16'h0, exp});
      check(extra_ok, "R9 surplus bits are zero", {31'h0, extra_ok}, 32'h1);
    end
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
    check(spi_dout_oe == 1'b0 && spi_dout == 1'b0, "R1 output disabled after frame",
          {30'h0, spi_dout_oe, spi_dout}, 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    logic [15:0] held;
    wait_clk(5);
    check(spi_dout_oe == 1'b0 && sample_stb == 1'b0 && ctl_valid == 1'b0,
          "R1 reset outputs", {29'h0, spi_dout_oe, sample_stb, ctl_valid}, 32'h0);
    rst_n = 1'b1;
    wait_clk(5);
    check(ctl_word == 16'h0, "R11 reset ctl_word", {16'h0, ctl_word}, 32'h0);

    frame(1'b0, 16, 16'h1234, 12'hA5C, 4'h9, 1'b1, 1'b0, "R5 R2 tagged layout idle-low");
    frame(1'b0, 16, 16'hBEEF, 12'hFFF, 4'h3, 1'b0, 1'b0, "R6 padded layout idle-low");
    frame(1'b1, 16, 16'h1234, 12'hA5C, 4'h9, 1'b1, 1'b0, "R8 tagged layout idle-high");
    frame(1'b1, 16, 16'h8001, 12'h3FF, 4'hC, 1'b1, 1'b1, "R7 tagged reduced resolution");
    frame(1'b0, 16, 16'h7FFE, 12'hFFF, 4'h0, 1'b0, 1'b1, "R7 padded reduced resolution");
    frame(1'b0, 21, 16'hC3A5, 12'h800, 4'hF, 1'b1, 1'b0, "R4 R9 surplus clocks");
    check(valid_seen == 6, "R9 one valid per long frame", valid_seen, 6);

    held = ctl_word;
    frame(1'b0, 7, 16'hFFFF, 12'h123, 4'h1, 1'b1, 1'b0, "R10 short frame");
    check(valid_seen == 6, "R10 no valid on short frame", valid_seen, 6);
    check(ctl_word == held, "R11 word held after short frame", {16'h0, ctl_word},
          {16'h0, held});

    frame(1'b1, 16, 16'h0F0F, 12'h5A5, 4'h6, 1'b0, 1'b0, "R10 fresh frame after abort");
    check(valid_seen == 7, "R3 valid count", valid_seen, 7);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    check(stb_seen == frames, "R1 one strobe per frame", stb_seen, frames);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule